// File: doc/BRIEF.md
# Byte-Bus GPIO Port with Write-One Strobes

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide register bus. It holds a direction latch and an output latch for its pins. Both latches can be written whole. They can also be changed through strobe addresses, where each 1 in the written byte sets, clears or toggles the matching bit and each 0 leaves that bit alone. A single bus write can therefore change any group of pins without a read-modify-write sequence, and pins that the write does not select are never disturbed.

The pads are sampled through a two-flop synchronizer before they reach the input register. Each pin has its own control byte with an input-sense field. Setting that field to its disable code makes the pin read as 0. Writing ones to the input register address toggles the corresponding output bits. Reads are combinational: `rdata` reflects the addressed register in the same cycle that `rd_en` is high, and is 0 otherwise.

Top module: `gpio_strobe_port`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the direction latch, the output latch and every pin control byte, so `pad_oe` and `pad_out` are 0.
- R2: A write to address 0x00 loads the direction latch, and `pad_oe` follows it from the next cycle (1 = output driver on). A cycle with no write changes neither latch.
- R3: Writes to 0x01, 0x02 and 0x03 set, clear and toggle the direction bits that are written as 1; bits written as 0 keep their value.
- R4: A write to 0x04 loads the output latch. Writes to 0x05, 0x06 and 0x07 set, clear and toggle the output bits that are written as 1, and leave the bits written as 0 unchanged. `pad_out` follows the output latch.
- R5: Writing to the input register at 0x08 toggles every output bit written as 1. It does not change the sampled pin value.
- R6: Reading a strobe address (0x01–0x03 or 0x05–0x07) returns the current direction or output latch.
- R7: Reading 0x08 returns `pad_in` as it was two clock edges earlier.
- R8: The control byte for pin n is read and written at 0x10+n. When its bits [2:0] equal 3'b100, pin n reads 0 at 0x08; any other value leaves the pin readable.
- R9: When a read and a write hit the same cycle, `rdata` shows the state from before the write. The write takes effect at the next edge.
- R10: Addresses 0x09–0x0F read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Register byte address within the port block |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational, 0 when not reading |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Output driver enable per pin |
| pad_out | output | 8 | Output level per pin |

## Verification
A read and a write can land in the same bus cycle. The case that matters is a strobe write to the output set address while the output register is being read. The bench asserts `rd_en` and `wr_en` together on one negative edge and checks that `rdata` still holds the latch value from before the write. It then reads again one cycle later and expects the merged value. A second overlap is a pad change racing the synchronizer. The bench samples the input register after one edge and again after two, and expects the old level on the first read and the new level on the second.

// File: rtl/gpio_strobe_port.sv
module gpio_strobe_port #(
  parameter int NPINS = 8,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [7:0]       rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);
  localparam logic [AW-1:0] A_DIR    = AW'(5'h00);
  localparam logic [AW-1:0] A_DIRSET = AW'(5'h01);
  localparam logic [AW-1:0] A_DIRCLR = AW'(5'h02);
  localparam logic [AW-1:0] A_DIRTGL = AW'(5'h03);
  localparam logic [AW-1:0] A_OUT    = AW'(5'h04);
  localparam logic [AW-1:0] A_OUTSET = AW'(5'h05);
  localparam logic [AW-1:0] A_OUTCLR = AW'(5'h06);
  localparam logic [AW-1:0] A_OUTTGL = AW'(5'h07);
  localparam logic [AW-1:0] A_IN     = AW'(5'h08);
  localparam int            CTRL_BASE = 16;
  localparam logic [2:0]    SENSE_OFF = 3'b100;

  logic [NPINS-1:0] dir_q, out_q, sync1, sync2, in_view;
  logic [7:0]       ctrl_q [NPINS];
  logic [NPINS-1:0] wbits;

  assign wbits   = wdata[NPINS-1:0];
  assign pad_oe  = dir_q;
  assign pad_out = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (wr_en) begin
        case (addr)
          A_DIR:    dir_q <= wbits;
          A_DIRSET: dir_q <= dir_q | wbits;
          A_DIRCLR: dir_q <= dir_q & ~wbits;
          A_DIRTGL: dir_q <= dir_q ^ wbits;
          A_OUT:    out_q <= wbits;
          A_OUTSET: out_q <= out_q | wbits;
          A_OUTCLR: out_q <= out_q & ~wbits;
          A_OUTTGL, A_IN: out_q <= out_q ^ wbits;
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) ctrl_q[n] <= '0;
      else if (wr_en && addr == AW'(CTRL_BASE + n)) ctrl_q[n] <= wdata;
    end
    assign in_view[n] = sync2[n] & (ctrl_q[n][2:0] != SENSE_OFF);
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_DIR, A_DIRSET, A_DIRCLR, A_DIRTGL: rdata = 8'(dir_q);
        A_OUT, A_OUTSET, A_OUTCLR, A_OUTTGL: rdata = 8'(out_q);
        A_IN:                                rdata = 8'(in_view);
        default:
          for (int n = 0; n < NPINS; n++)
            if (addr == AW'(CTRL_BASE + n)) rdata = ctrl_q[n];
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

  assert_dirset_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIRSET) |=>
      ((pad_oe & $past(wbits)) == $past(wbits)) &&
      ((pad_oe & ~$past(wbits)) == ($past(pad_oe) & ~$past(wbits))));

  assert_outclr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OUTCLR) |=>
      ((pad_out & $past(wbits)) == '0) && $stable(pad_oe));

  assert_in_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IN) |=> (pad_out == ($past(pad_out) ^ $past(wbits))));

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > A_IN && addr < AW'(CTRL_BASE)) |=>
      ($stable(pad_oe) && $stable(pad_out)));

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > A_IN && addr < AW'(CTRL_BASE)) |-> rdata == 8'h00);
endmodule

// File: tb/gpio_strobe_port_test.sv
`timescale 1ns/1ps
module gpio_strobe_port_test;
  logic       clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_oe, pad_out;
  int total = 0, bad = 0;
  bit done = 0;

  gpio_strobe_port uut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out));

  always #2 clk = ~clk;

  // {addr, wdata, expected pad_oe, expected pad_out}
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {5'h00, 8'hA5, 8'hA5, 8'h00},
    {5'h01, 8'h0A, 8'hAF, 8'h00},
    {5'h02, 8'h81, 8'h2E, 8'h00},
    {5'h03, 8'hF0, 8'hDE, 8'h00},
    {5'h04, 8'h3C, 8'hDE, 8'h3C},
    {5'h05, 8'h81, 8'hDE, 8'hBD},
    {5'h06, 8'h0C, 8'hDE, 8'hB1},
    {5'h07, 8'hFF, 8'hDE, 8'h4E},
    {5'h08, 8'h0F, 8'hDE, 8'h41},
    {5'h0C, 8'hFF, 8'hDE, 8'h41},
    {5'h01, 8'h00, 8'hDE, 8'h41},
    {5'h06, 8'h00, 8'hDE, 8'h41}
  };

  function automatic string tag(input logic [4:0] a);
    if (a == 5'h00) return "R2";
    if (a >= 5'h01 && a <= 5'h03) return "R3";
    if (a >= 5'h04 && a <= 5'h07) return "R4";
    if (a == 5'h08) return "R5";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rd_en = 1;
    #1 check(req, rdata, exp);
    rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", pad_oe, 8'h00);
    check("R1", pad_out, 8'h00);
    rd_check("R1", 5'h10, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][28:24], VEC[i][23:16]);
      check(tag(VEC[i][28:24]), pad_oe, VEC[i][15:8]);
      check(tag(VEC[i][28:24]), pad_out, VEC[i][7:0]);
    end

    rd_check("R6", 5'h01, 8'hDE);
    rd_check("R6", 5'h07, 8'h41);
    rd_check("R10", 5'h0C, 8'h00);

    // R7: two-edge synchronizer latency
    @(negedge clk); pad_in = 8'h5A;
    rd_check("R7", 5'h08, 8'h00);
    rd_check("R7", 5'h08, 8'h5A);

    // R8: per-pin sense field, 3'b100 disables the pin
    wr(5'h11, 8'h04);
    rd_check("R8", 5'h11, 8'h04);
    rd_check("R8", 5'h08, 8'h58);
    wr(5'h13, 8'h0B);
    rd_check("R8", 5'h08, 8'h58);
    wr(5'h11, 8'h00);
    rd_check("R8", 5'h08, 8'h5A);

    // R9: read and write on the same cycle
    @(negedge clk); addr = 5'h05; wdata = 8'h02; wr_en = 1; rd_en = 1;
    #1 check("R9", rdata, 8'h41);
    @(negedge clk); wr_en = 0; addr = 5'h04;
    #1 check("R9", rdata, 8'h43);
    rd_en = 0;

    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1", pad_oe, 8'h00);
    check("R1", pad_out, 8'h00);
    rd_check("R1", 5'h13, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule